// File: doc/BRIEF.md
# Eight-Port Transceiver Management Register Decoder

This block is the management-side register logic of an eight-port Ethernet transceiver. It receives serial management frames on a single data line clocked by the management clock. It decodes reads and writes, and it lets only the addressed port answer. When reset is released it holds the two high address straps, the pause strap and the forced-full-duplex strap. Port n answers to the address formed by the two strap bits above its three-bit index.

Each port has three implemented registers. The control register (address 0) carries the auto-negotiation enable at bit 12. The advertisement register (address 4) holds a fixed selector, four ability bits and a pause bit. The partner register (address 5) holds the partner pause bit. The pause bits change their reset value and their writability with the pause strap and with the negotiation state. Simple per-port inputs report negotiation results and parallel-detect results. From these the block resolves each port's link speed and duplex.

A parameter marks ports as fiber. A fiber port never negotiates, and its enable bit reads 0.

Top module: `octal_phy_mgmt`

## Requirements
- R1: The address straps, the pause strap and the full-duplex strap are sampled only while `rst_n` is low and are held from its release; strap changes after release have no effect on addressing.
- R2: Port n (0..7) answers to the 5-bit address {strap_addr[1:0], n[2:0]}.
- R3: A frame whose PHY address matches no port changes no register, and `mdio_oe` stays 0 for the whole frame.
- R4: Frames are at least 32 ones, start bits 0 then 1, opcode (10 read, 01 write), 5-bit PHY address and 5-bit register address, all MSB first and sampled on rising `mdc`. For a matching read, `mdio_oe` rises one cycle after the last register-address bit. `mdio_out` is 0 for that turnaround cycle, then carries the 16 data bits MSB first, and `mdio_oe` falls after the last data bit (17 driven cycles).
- R5: A matching write carries two turnaround bits and then 16 data bits MSB first, and the data takes effect in the addressed port's register.
- R6: A copper port resets with register 0 bit 12 = 1; writing bit 12 = 0 clears it, writing 1 sets it; register 0 reads as that bit alone (0x1000 or 0x0000).
- R7: A fiber port always reads register 0 as 0x0000 and never negotiates, whatever is written.
- R8: Register 4 bit 10 and register 5 bit 10 reset to the value of the pause strap.
- R9: Register 4 reads {5'b0, pause, 1'b0, ability[3:0], 5'b00001}; pause and ability are writable in any mode (ability resets to 4'b1111). While negotiation is enabled, writes to register 5 are ignored and a `lp_done` pulse loads `lp_pause` into register 5 bit 10.
- R10: While negotiation is disabled, register 5 bit 10 is writable, keeps its strap value until written, and `lp_done` leaves it unchanged.
- R11: On an `lp_pdet` pulse without `lp_done`, with negotiation enabled, `link_speed100` takes `lp_speed100` and `link_full` takes the full-duplex strap held at reset.
- R12: On an `lp_done` pulse with negotiation enabled, `link_speed100` and `link_full` take `lp_speed100` and `lp_full` on the next rising edge; with negotiation disabled both pulses are ignored; both outputs reset to 0.
- R13: Register addresses other than 0, 4 and 5 read as 0x0000 and ignore writes.
- R14: A frame with a preamble shorter than 32 ones, or with opcode 00 or 11, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| strap_addr | input | 2 | High bits of the port addresses |
| strap_pause | input | 1 | Pause ability strap |
| strap_par_full | input | 1 | Duplex used after parallel detect (1 = full) |
| mdio_in | input | 1 | Serial management data from the station |
| mdio_out | output | 1 | Serial read data toward the station |
| mdio_oe | output | 1 | Drive enable for `mdio_out` |
| lp_done | input | 8 | Per-port pulse: negotiation finished |
| lp_pdet | input | 8 | Per-port pulse: parallel detect finished |
| lp_speed100 | input | 8 | Per-port partner speed (1 = 100 Mb/s) |
| lp_full | input | 8 | Per-port negotiated duplex (1 = full) |
| lp_pause | input | 8 | Per-port partner pause ability |
| link_speed100 | output | 8 | Per-port resolved speed |
| link_full | output | 8 | Per-port resolved duplex |

## Verification
The bench goes after the pause-bit mode switch. A design that ignored the negotiation state would let a write land in register 5 while negotiation runs, or let a negotiation result overwrite a value the station wrote. It checks addressing after the straps change once reset is over, because a design that samples the straps all the time would move its address group. It also sends reads to foreign addresses, short preambles, illegal opcodes and unimplemented registers. A design that is loose about any of these would drive the line or corrupt a register. Parallel-detect duplex is checked under both strap values, which catches a design that uses a fixed duplex or the negotiated one.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
   localparam int PHYAW     = 5;
   localparam int REGAW     = 5;
   localparam int DATAW     = 16;
   localparam int HDRW      = 13;   // start bit 2, opcode, phy, reg
   localparam logic [REGAW-1:0] REG_CTRL = 5'd0;
   localparam logic [REGAW-1:0] REG_ADV  = 5'd4;
   localparam logic [REGAW-1:0] REG_LPA  = 5'd5;
   localparam int BIT_AN    = 12;
   localparam int BIT_PAUSE = 10;
   localparam int ABIL_LO   = 5;
   localparam int ABIL_HI   = 8;
   localparam logic [4:0] SELECTOR = 5'b00001;
   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] OP_WR = 2'b01;

   typedef enum logic [1:0] {
      FS_IDLE, FS_HDR, FS_TA, FS_DATA
   } frm_state_t;
endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
   import mgmt_pkg::*;
#(
   parameter int PREAMBLE_LEN = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mdio_in,
   input  logic             hit,
   input  logic [DATAW-1:0] rd_data,
   output logic [PHYAW-1:0] frm_phy,
   output logic [REGAW-1:0] frm_reg,
   output logic             wr_stb,
   output logic [DATAW-1:0] wr_data,
   output logic             mdio_out,
   output logic             mdio_oe
);
   localparam int CNTW = $clog2(PREAMBLE_LEN + 1);
   localparam logic [CNTW-1:0] PRE_MAX = CNTW'(PREAMBLE_LEN);

   generate
      if (PREAMBLE_LEN < 1 || PREAMBLE_LEN > 64) begin : g_bad_pre
         $error("PREAMBLE_LEN out of range");
      end
   endgenerate

   frm_state_t       st;
   logic [CNTW-1:0]  pre_cnt;
   logic [3:0]       bit_cnt;
   logic [HDRW-2:0]  hdr;
   logic             is_rd;
   logic [DATAW-1:0] shreg;
   logic [HDRW-1:0]  hdr_full;
   logic             hdr_ok;

   assign hdr_full = {hdr, mdio_in};
   assign hdr_ok   = hdr_full[12] &&
                     (hdr_full[11:10] == OP_RD || hdr_full[11:10] == OP_WR);
   assign wr_stb   = (st == FS_DATA) && (bit_cnt == 4'd15) && !is_rd;
   assign wr_data  = {shreg[DATAW-2:0], mdio_in};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= FS_IDLE;
         pre_cnt  <= '0;
         bit_cnt  <= '0;
         hdr      <= '0;
         is_rd    <= 1'b0;
         shreg    <= '0;
         frm_phy  <= '0;
         frm_reg  <= '0;
         mdio_out <= 1'b0;
         mdio_oe  <= 1'b0;
      end else begin
         case (st)
            FS_IDLE: begin
               mdio_oe <= 1'b0;
               if (mdio_in) begin
                  if (pre_cnt != PRE_MAX) pre_cnt <= pre_cnt + 1'b1;
               end else begin
                  if (pre_cnt == PRE_MAX) begin
                     st      <= FS_HDR;
                     bit_cnt <= '0;
                  end
                  pre_cnt <= '0;
               end
            end
            FS_HDR: begin
               hdr     <= {hdr[HDRW-3:0], mdio_in};
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == 4'(HDRW - 1)) begin
                  frm_phy <= hdr_full[9:5];
                  frm_reg <= hdr_full[4:0];
                  is_rd   <= (hdr_full[11:10] == OP_RD);
                  bit_cnt <= '0;
                  st      <= hdr_ok ? FS_TA : FS_IDLE;
               end
            end
            FS_TA: begin
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == 4'd0) begin
                  mdio_oe  <= is_rd && hit;
                  mdio_out <= 1'b0;
                  shreg    <= rd_data;
               end else begin
                  st       <= FS_DATA;
                  bit_cnt  <= '0;
                  mdio_out <= shreg[DATAW-1];
                  shreg    <= {shreg[DATAW-2:0], 1'b0};
               end
            end
            default: begin
               mdio_out <= shreg[DATAW-1];
               shreg    <= {shreg[DATAW-2:0], mdio_in};
               bit_cnt  <= bit_cnt + 1'b1;
               if (bit_cnt == 4'd15) begin
                  st      <= FS_IDLE;
                  mdio_oe <= 1'b0;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/mgmt_port_regs.sv
module mgmt_port_regs
   import mgmt_pkg::*;
#(
   parameter bit IS_FIBER = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_pause,
   input  logic             par_full,
   input  logic             wr_en,
   input  logic [REGAW-1:0] acc_reg,
   input  logic [DATAW-1:0] wr_data,
   output logic [DATAW-1:0] rd_data,
   input  logic             lp_done,
   input  logic             lp_pdet,
   input  logic             lp_speed100,
   input  logic             lp_full,
   input  logic             lp_pause,
   output logic             an_en,
   output logic             pause_lp,
   output logic             link_speed100,
   output logic             link_full
);
   logic       pause_adv;
   logic [3:0] abil;

   generate
      if (IS_FIBER) begin : g_fiber
         assign an_en = 1'b0;
      end else begin : g_copper
         logic an_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               an_q <= 1'b1;
            else if (wr_en && acc_reg == REG_CTRL)
               an_q <= wr_data[BIT_AN];
         end
         assign an_en = an_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pause_adv     <= init_pause;
         abil          <= '1;
         pause_lp      <= init_pause;
         link_speed100 <= 1'b0;
         link_full     <= 1'b0;
      end else begin
         if (wr_en && acc_reg == REG_ADV) begin
            pause_adv <= wr_data[BIT_PAUSE];
            abil      <= wr_data[ABIL_HI:ABIL_LO];
         end
         if (an_en) begin
            if (lp_done) pause_lp <= lp_pause;
         end else if (wr_en && acc_reg == REG_LPA) begin
            pause_lp <= wr_data[BIT_PAUSE];
         end
         if (an_en && lp_done) begin
            link_speed100 <= lp_speed100;
            link_full     <= lp_full;
         end else if (an_en && lp_pdet) begin
            link_speed100 <= lp_speed100;
            link_full     <= par_full;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      case (acc_reg)
         REG_CTRL: rd_data[BIT_AN] = an_en;
         REG_ADV: begin
            rd_data[BIT_PAUSE]       = pause_adv;
            rd_data[ABIL_HI:ABIL_LO] = abil;
            rd_data[4:0]             = SELECTOR;
         end
         REG_LPA:  rd_data[BIT_PAUSE] = pause_lp;
         default:  rd_data = '0;
      endcase
   end

   logic unused_wr;
   assign unused_wr = ^{wr_data[15:13], wr_data[11], wr_data[9], wr_data[4:0]};
endmodule

// File: rtl/octal_phy_mgmt.sv
module octal_phy_mgmt
   import mgmt_pkg::*;
#(
   parameter int                NPORTS       = 8,
   parameter logic [NPORTS-1:0] FIBER_MASK   = '0,
   parameter int                PREAMBLE_LEN = 32,
   localparam int               IDXW         = $clog2(NPORTS),
   localparam int               STRAPW       = PHYAW - IDXW
) (
   input  logic              mdc,
   input  logic              rst_n,
   input  logic [STRAPW-1:0] strap_addr,
   input  logic              strap_pause,
   input  logic              strap_par_full,
   input  logic              mdio_in,
   output logic              mdio_out,
   output logic              mdio_oe,
   input  logic [NPORTS-1:0] lp_done,
   input  logic [NPORTS-1:0] lp_pdet,
   input  logic [NPORTS-1:0] lp_speed100,
   input  logic [NPORTS-1:0] lp_full,
   input  logic [NPORTS-1:0] lp_pause,
   output logic [NPORTS-1:0] link_speed100,
   output logic [NPORTS-1:0] link_full
);
   generate
      if (NPORTS < 2 || NPORTS > 16 || (1 << IDXW) != NPORTS) begin : g_bad_n
         $error("NPORTS must be a power of two from 2 to 16");
      end
   endgenerate

   logic [STRAPW-1:0] strap_q;
   logic              par_full_q;
   logic [PHYAW-1:0]  frm_phy;
   logic [REGAW-1:0]  frm_reg;
   logic              wr_stb;
   logic [DATAW-1:0]  wr_data;
   logic [DATAW-1:0]  rd_mux;
   logic              hit;
   logic [NPORTS-1:0] match;
   logic [NPORTS-1:0] an_en;
   logic [NPORTS-1:0] pause_lp;
   logic [DATAW-1:0]  port_rd [NPORTS];

   // straps follow the pins during reset and freeze at its release
   always_ff @(posedge mdc) begin
      if (!rst_n) begin
         strap_q    <= strap_addr;
         par_full_q <= strap_par_full;
      end
   end

   mdio_frame_rx #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_rx (
      .clk(mdc), .rst_n(rst_n), .mdio_in(mdio_in), .hit(hit),
      .rd_data(rd_mux), .frm_phy(frm_phy), .frm_reg(frm_reg),
      .wr_stb(wr_stb), .wr_data(wr_data),
      .mdio_out(mdio_out), .mdio_oe(mdio_oe)
   );

   for (genvar i = 0; i < NPORTS; i++) begin : g_port
      assign match[i] = (frm_phy == {strap_q, IDXW'(i)});

      mgmt_port_regs #(.IS_FIBER(FIBER_MASK[i])) u_regs (
         .clk(mdc), .rst_n(rst_n),
         .init_pause(strap_pause), .par_full(par_full_q),
         .wr_en(wr_stb && match[i]), .acc_reg(frm_reg),
         .wr_data(wr_data), .rd_data(port_rd[i]),
         .lp_done(lp_done[i]), .lp_pdet(lp_pdet[i]),
         .lp_speed100(lp_speed100[i]), .lp_full(lp_full[i]),
         .lp_pause(lp_pause[i]), .an_en(an_en[i]),
         .pause_lp(pause_lp[i]),
         .link_speed100(link_speed100[i]), .link_full(link_full[i])
      );
   end

   assign hit = |match;

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NPORTS; i++)
         if (match[i]) rd_mux = rd_mux | port_rd[i];
   end
endmodule

// File: rtl/octal_phy_mgmt_chk.sv
module octal_phy_mgmt_chk #(
   parameter int NPORTS = 8,
   parameter int STRAPW = 2
) (
   input logic              mdc,
   input logic              rst_n,
   input logic [STRAPW-1:0] strap_q,
   input logic              par_full_q,
   input logic              hit,
   input logic              mdio_out,
   input logic              mdio_oe,
   input logic [NPORTS-1:0] an_en,
   input logic [NPORTS-1:0] pause_lp,
   input logic [NPORTS-1:0] lp_done,
   input logic [NPORTS-1:0] lp_pdet,
   input logic [NPORTS-1:0] lp_pause,
   input logic [NPORTS-1:0] link_full
);
   logic [4:0] oe_run;

   always_ff @(posedge mdc) begin
      if (!rst_n)       oe_run <= '0;
      else if (mdio_oe) oe_run <= oe_run + 1'b1;
      else              oe_run <= '0;
   end

   AST_STRAP_HOLD: assert property (@(posedge mdc) disable iff (!rst_n)
      $past(rst_n) |-> $stable(strap_q)); // R1
   AST_OE_NEEDS_HIT: assert property (@(posedge mdc) disable iff (!rst_n)
      $rose(mdio_oe) |-> hit); // R3
   AST_TA_ZERO: assert property (@(posedge mdc) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_out); // R4
   AST_OE_LEN: assert property (@(posedge mdc) disable iff (!rst_n)
      oe_run <= 5'd17); // R4

   for (genvar i = 0; i < NPORTS; i++) begin : g_port_chk
      AST_LPA_LOCKED: assert property (@(posedge mdc) disable iff (!rst_n)
         (an_en[i] && !lp_done[i]) |=> $stable(pause_lp[i])); // R9
      AST_LPA_LOAD: assert property (@(posedge mdc) disable iff (!rst_n)
         (an_en[i] && lp_done[i]) |=> (pause_lp[i] == $past(lp_pause[i]))); // R9
      AST_PDET_DUPLEX: assert property (@(posedge mdc) disable iff (!rst_n)
         (an_en[i] && lp_pdet[i] && !lp_done[i]) |=> (link_full[i] == par_full_q)); // R11
   end
endmodule

bind octal_phy_mgmt octal_phy_mgmt_chk #(.NPORTS(NPORTS), .STRAPW(STRAPW)) u_chk (
   .mdc(mdc), .rst_n(rst_n), .strap_q(strap_q), .par_full_q(par_full_q),
   .hit(hit), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .an_en(an_en),
   .pause_lp(pause_lp), .lp_done(lp_done), .lp_pdet(lp_pdet),
   .lp_pause(lp_pause), .link_full(link_full)
);

// File: tb/tb_octal_phy_mgmt.sv
`timescale 1ns/1ps
module tb_octal_phy_mgmt;
   localparam logic [7:0] FMASK = 8'h80;

   logic       mdc = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] strap_addr = 2'b10;
   logic       strap_pause = 1'b1;
   logic       strap_par_full = 1'b1;
   logic       mdio_in = 1'b1;
   logic       mdio_out, mdio_oe;
   logic [7:0] lp_done = '0, lp_pdet = '0, lp_speed100 = '0, lp_full = '0, lp_pause = '0;
   logic [7:0] link_speed100, link_full;

   int nvec = 0;
   int nfail = 0;

   // expected-state model
   bit       m_an [8];
   bit       m_adv [8];
   bit [3:0] m_abil [8];
   bit       m_lpp [8];
   bit       m_spd [8];
   bit       m_full [8];
   bit [1:0] m_strap;
   bit       m_pause, m_pfull;

   always #10 mdc = ~mdc;

   octal_phy_mgmt #(.NPORTS(8), .FIBER_MASK(FMASK)) dut (
      .mdc(mdc), .rst_n(rst_n), .strap_addr(strap_addr),
      .strap_pause(strap_pause), .strap_par_full(strap_par_full),
      .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
      .lp_done(lp_done), .lp_pdet(lp_pdet), .lp_speed100(lp_speed100),
      .lp_full(lp_full), .lp_pause(lp_pause),
      .link_speed100(link_speed100), .link_full(link_full)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_rd(input int p, input logic [4:0] rg);
      case (rg)
         5'd0: return 16'(m_an[p]) << 12;
         5'd4: return (16'(m_adv[p]) << 10) | (16'(m_abil[p]) << 5) | 16'h0001;
         5'd5: return 16'(m_lpp[p]) << 10;
         default: return 16'h0000;
      endcase
   endfunction

   task automatic m_reset();
      m_strap = strap_addr; m_pause = strap_pause; m_pfull = strap_par_full;
      for (int p = 0; p < 8; p++) begin
         m_an[p] = !FMASK[p]; m_adv[p] = m_pause; m_abil[p] = 4'hF;
         m_lpp[p] = m_pause; m_spd[p] = 0; m_full[p] = 0;
      end
   endtask

   task automatic m_write(input int p, input logic [4:0] rg, input logic [15:0] d);
      case (rg)
         5'd0: m_an[p] = FMASK[p] ? 1'b0 : d[12];
         5'd4: begin m_adv[p] = d[10]; m_abil[p] = d[8:5]; end
         5'd5: if (!m_an[p]) m_lpp[p] = d[10];
         default: ;
      endcase
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge mdc);
      m_reset();
      rst_n = 1'b1;
      @(negedge mdc);
   endtask

   task automatic send_bit(input logic b);
      @(negedge mdc);
      mdio_in = b;
   endtask

   task automatic send_hdr(input int npre, input logic [1:0] op,
                           input logic [4:0] phy, input logic [4:0] rg);
      for (int i = 0; i < npre; i++) send_bit(1'b1);
      send_bit(1'b0); send_bit(1'b1);
      send_bit(op[1]); send_bit(op[0]);
      for (int i = 4; i >= 0; i--) send_bit(phy[i]);
      for (int i = 4; i >= 0; i--) send_bit(rg[i]);
   endtask

   task automatic mwrite(input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] d, input logic [1:0] op = 2'b01,
                         input int npre = 32);
      send_hdr(npre, op, phy, rg);
      send_bit(1'b1); send_bit(1'b0);
      for (int i = 15; i >= 0; i--) send_bit(d[i]);
      send_bit(1'b1);
   endtask

   // returns data, whether the drive window was exactly right, and any drive seen
   task automatic mread(input logic [4:0] phy, input logic [4:0] rg,
                        output logic [15:0] d, output logic ok, output logic any_oe);
      logic oe_pre, ta, oe_all, oe_post;
      send_hdr(32, 2'b10, phy, rg);
      @(negedge mdc); mdio_in = 1'b1; oe_pre = mdio_oe;
      @(negedge mdc); ta = mdio_oe && !mdio_out;
      any_oe = oe_pre | mdio_oe;
      oe_all = 1'b1;
      d = '0;
      for (int i = 0; i < 16; i++) begin
         @(negedge mdc);
         d = {d[14:0], mdio_out};
         oe_all &= mdio_oe;
         any_oe |= mdio_oe;
      end
      @(negedge mdc); oe_post = mdio_oe; any_oe |= mdio_oe;
      ok = !oe_pre && ta && oe_all && !oe_post;
   endtask

   task automatic lp_pulse(input int p, input bit done, input bit pdet,
                           input bit spd, input bit full, input bit pau);
      @(negedge mdc);
      lp_done[p] = done; lp_pdet[p] = pdet; lp_speed100[p] = spd;
      lp_full[p] = full; lp_pause[p] = pau;
      if (m_an[p]) begin
         if (done) begin m_spd[p] = spd; m_full[p] = full; m_lpp[p] = pau; end
         else if (pdet) begin m_spd[p] = spd; m_full[p] = m_pfull; end
      end
      @(negedge mdc);
      lp_done = '0; lp_pdet = '0;
      chk(done ? "R12 speed" : "R11 speed", link_speed100[p], m_spd[p]);
      chk(done ? "R12 duplex" : "R11 duplex", link_full[p], m_full[p]);
   endtask

   task automatic read_chk(input string req, input int p, input logic [4:0] rg);
      logic [15:0] d; logic ok, any;
      mread({m_strap, 3'(p)}, rg, d, ok, any);
      chk(req, {15'd0, ok, d}, {15'd0, 1'b1, exp_rd(p, rg)});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge mdc);
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin : main
      logic [15:0] d; logic ok, any;
      void'($urandom(32'h5EED1234));
      do_reset();

      // reset state
      chk("R12 reset speed", link_speed100, 8'h00);
      chk("R12 reset duplex", link_full, 8'h00);
      chk("R4 idle oe", mdio_oe, 1'b0);

      // R2: every port at its own address, R6 / R7 reset view, R8 pause init
      for (int p = 0; p < 8; p++) read_chk("R2 R6 R7 reg0 per port", p, 5'd0);
      read_chk("R8 R9 reg4", 3, 5'd4);
      read_chk("R8 reg5", 3, 5'd5);

      // R1: strap pins move after reset; address group must not
      strap_addr = 2'b01;
      read_chk("R1 held address", 0, 5'd4);
      mread(5'b01000, 5'd4, d, ok, any);
      chk("R1 new strap address unused", any, 1'b0);
      strap_addr = 2'b10;

      // R3: foreign address write and read
      mwrite(5'b00010, 5'd4, 16'h0000);
      read_chk("R3 no change from foreign write", 2, 5'd4);
      mread(5'b11101, 5'd0, d, ok, any);
      chk("R3 no drive on foreign read", any, 1'b0);

      // R5 / R9: write register 4 on port 1
      mwrite({m_strap, 3'd1}, 5'd4, 16'h0140); m_write(1, 5'd4, 16'h0140);
      read_chk("R5 R9 reg4 write", 1, 5'd4);

      // R9: register 5 locked while negotiating, loaded on lp_done
      mwrite({m_strap, 3'd4}, 5'd5, 16'h0000); m_write(4, 5'd5, 16'h0000);
      read_chk("R9 reg5 write ignored", 4, 5'd5);
      lp_pulse(4, 1, 0, 1, 1, 0);
      read_chk("R9 reg5 from partner", 4, 5'd5);

      // R6 / R10: disable negotiation on port 6
      mwrite({m_strap, 3'd6}, 5'd0, 16'h0000); m_write(6, 5'd0, 16'h0000);
      read_chk("R6 an cleared", 6, 5'd0);
      read_chk("R10 reg5 keeps strap", 6, 5'd5);
      lp_pulse(6, 1, 0, 1, 1, 0);
      read_chk("R10 lp_done ignored", 6, 5'd5);
      lp_pulse(6, 0, 1, 1, 0, 0);
      mwrite({m_strap, 3'd6}, 5'd5, 16'h0000); m_write(6, 5'd5, 16'h0000);
      read_chk("R10 reg5 written", 6, 5'd5);
      mwrite({m_strap, 3'd6}, 5'd0, 16'h1000); m_write(6, 5'd0, 16'h1000);
      read_chk("R6 an set again", 6, 5'd0);

      // R7: fiber port ignores enable
      mwrite({m_strap, 3'd7}, 5'd0, 16'hFFFF); m_write(7, 5'd0, 16'hFFFF);
      read_chk("R7 fiber reg0", 7, 5'd0);
      lp_pulse(7, 0, 1, 1, 1, 1);

      // R11: parallel detect with full strap
      lp_pulse(2, 0, 1, 1, 0, 0);

      // R13: unimplemented register
      mwrite({m_strap, 3'd3}, 5'd2, 16'hFFFF);
      read_chk("R13 reg2 zero", 3, 5'd2);

      // R14: bad opcode and short preamble
      mwrite({m_strap, 3'd5}, 5'd4, 16'h0000, 2'b11, 32);
      read_chk("R14 opcode 11 ignored", 5, 5'd4);
      mwrite({m_strap, 3'd5}, 5'd4, 16'h0000, 2'b00, 32);
      read_chk("R14 opcode 00 ignored", 5, 5'd4);
      mwrite({m_strap, 3'd5}, 5'd4, 16'h0000, 2'b01, 20);
      read_chk("R14 short preamble ignored", 5, 5'd4);

      // constrained random mix
      for (int it = 0; it < 60; it++) begin
         int p; logic [4:0] rg; logic [15:0] wd; bit foreign;
         logic [4:0] regs [6];
         regs = '{5'd0, 5'd4, 5'd5, 5'd1, 5'd2, 5'd31};
         p = $urandom % 8;
         rg = regs[$urandom % 6];
         wd = 16'($urandom);
         foreign = ($urandom % 8) == 0;
         if ($urandom % 2) begin
            if (foreign) mwrite({~m_strap, 3'(p)}, rg, wd);
            else begin mwrite({m_strap, 3'(p)}, rg, wd); m_write(p, rg, wd); end
         end else if (foreign) begin
            mread({~m_strap, 3'(p)}, rg, d, ok, any);
            chk("R3 random foreign read", any, 1'b0);
         end else begin
            read_chk("R5 R9 R10 R13 random read", p, rg);
         end
         if ($urandom % 3 == 0)
            lp_pulse($urandom % 8, $urandom % 2, $urandom % 2,
                     $urandom % 2, $urandom % 2, $urandom % 2);
      end
      for (int p = 0; p < 8; p++) begin
         read_chk("R9 R10 final reg5", p, 5'd5);
         read_chk("R6 R7 final reg0", p, 5'd0);
      end

      // second reset with other straps
      strap_addr = 2'b01; strap_pause = 1'b0; strap_par_full = 1'b0;
      do_reset();
      read_chk("R8 reg4 pause strap 0", 3, 5'd4);
      read_chk("R8 reg5 pause strap 0", 3, 5'd5);
      read_chk("R2 new group", 0, 5'd0);
      lp_pulse(2, 0, 1, 1, 1, 0);
      lp_pulse(2, 1, 1, 0, 1, 1);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule